// File: doc/BRIEF.md
# Prescaled Up/Down Reload Timer

A general-purpose counter that steps once every N qualifying clock strobes, where N is a programmable prescale value plus one. Two strobe sources run in the same clock domain: a fast strobe taken from the divided system clock and a slow low-power strobe. A select input picks one of them, and a gate input can pause counting without losing state. All settings come in as plain configuration inputs from the register bank beside the block. The block returns the live counter and the live prescale count.

In up mode the counter climbs to a programmable limit and then returns to zero. In down mode it falls to zero and then loads the limit again. A free-run option, which applies only to up mode, ignores the limit and lets the counter climb to its full-width maximum before it returns to zero. Each wrap or reload is a terminal event. The event sets a sticky flag, and the flag drives the interrupt output through a mask. A one-cycle clear pulse drops the flag.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, countVal, prescaleCnt and irqOut are all 0.
- R2: While running, prescaleCnt advances by one on each selected strobe. On the strobe that finds prescaleCnt >= prescaleVal, prescaleCnt returns to 0 and the counter takes one step, so the counter steps once every prescaleVal+1 selected strobes.
- R3: clkSel=1 selects sysTick and clkSel=0 selects lpTick. The strobe that is not selected has no effect.
- R4: With enable=1 and clkEn=0, countVal and prescaleCnt hold their values.
- R5: In up mode (countDown=0) with freeRun=0, a step from a value >= reloadVal goes to 0 and is a terminal event. Any other step adds 1.
- R6: In up mode with freeRun=1, reloadVal is ignored. The counter goes to 0 only on the step taken from the all-ones value, and that step is a terminal event.
- R7: In down mode (countDown=1), a step from 0 loads reloadVal and is a terminal event. Any other step subtracts 1. freeRun has no effect in this mode.
- R8: A terminal event sets the interrupt flag. irqOut equals the flag ANDed with irqEn, and the flag is set whatever the value of irqEn.
- R9: A one-cycle irqClear clears the flag. A terminal event in the same cycle takes priority over the clear.
- R10: While enable=0, countVal and prescaleCnt are forced to 0 and no terminal event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Timer run enable |
| clkEn | input | 1 | Count gate |
| clkSel | input | 1 | 1 = system strobe, 0 = low-power strobe |
| sysTick | input | 1 | Divided system clock strobe |
| lpTick | input | 1 | Low-power clock strobe |
| countDown | input | 1 | 1 = count down, 0 = count up |
| freeRun | input | 1 | Up-mode wrap at full-width maximum |
| irqEn | input | 1 | Interrupt mask, 1 = unmasked |
| irqClear | input | 1 | Clear pulse for the interrupt flag |
| prescaleVal | input | PRE_W | Prescale divide minus one |
| reloadVal | input | CNT_W | Wrap limit / reload value |
| countVal | output | CNT_W | Live counter value |
| prescaleCnt | output | PRE_W | Live prescaler count |
| irqOut | output | 1 | Masked interrupt |

## Verification
The bench builds the block with CNT_W=8 and the default PRE_W=5. The narrow counter puts the free-run wrap at 255 within a few hundred cycles, which a 24-bit counter could never reach in a short run. The full 5-bit prescaler field is kept so that a divide of 32 can be exercised. A behavioural model runs next to the design and checks every output on every cycle, through all strobe selections, directions and interrupt clear races.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic zero;  // force counter to zero (timer disabled)
    logic step;  // one prescaled count step
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import timer_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             clkEn,
  input  logic             clkSel,
  input  logic             sysTick,
  input  logic             lpTick,
  input  logic [PRE_W-1:0] prescaleVal,
  input  logic             irqEn,
  input  logic             irqClear,
  input  logic             termEvt,
  output tmrStrobe_t       strobe,
  output logic [PRE_W-1:0] prescaleCnt,
  output logic             irqOut
);
  logic srcTick;
  logic liveTick;
  logic preWrap;
  logic irqFlag;

  assign srcTick  = clkSel ? sysTick : lpTick;
  assign liveTick = enable & clkEn & srcTick;
  assign preWrap  = liveTick & (prescaleCnt >= prescaleVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescaleCnt <= '0;
    end else if (!enable) begin
      prescaleCnt <= '0;
    end else if (liveTick) begin
      prescaleCnt <= preWrap ? '0 : prescaleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
    end else if (termEvt) begin
      irqFlag <= 1'b1;
    end else if (irqClear) begin
      irqFlag <= 1'b0;
    end
  end

  always_comb begin
    strobe.zero = ~enable;
    strobe.step = preWrap;
  end

  assign irqOut = irqFlag & irqEn;

  AST_PRE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !liveTick) |=> $stable(prescaleCnt)) else $error("prescaler moved"); // R4
  AST_PRE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (prescaleCnt == '0)) else $error("prescaler not zero"); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    termEvt |=> irqFlag) else $error("flag not set"); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !termEvt) |=> !irqFlag) else $error("flag not cleared"); // R9
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             countDown,
  input  logic             freeRun,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countVal,
  output logic             termEvt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] upLimit;
  logic             atEnd;

  assign upLimit = freeRun ? CNT_MAX : reloadVal;
  assign atEnd   = countDown ? (countVal == '0) : (countVal >= upLimit);
  assign termEvt = strobe.step & ~strobe.zero & atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.zero) begin
      countVal <= '0;
    end else if (strobe.step) begin
      if (countDown) countVal <= atEnd ? reloadVal : countVal - 1'b1;
      else           countVal <= atEnd ? '0 : countVal + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.zero && !strobe.step) |=> $stable(countVal)) else $error("count moved"); // R4
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.zero && !countDown && !atEnd) |=> (countVal == $past(countVal) + 1'b1))
    else $error("up step wrong"); // R5
  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.zero && countDown && countVal == '0) |=> (countVal == $past(reloadVal)))
    else $error("reload wrong"); // R7
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> (countVal == '0)) else $error("count not zero"); // R10
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             clkEn,
  input  logic             clkSel,
  input  logic             sysTick,
  input  logic             lpTick,
  input  logic             countDown,
  input  logic             freeRun,
  input  logic             irqEn,
  input  logic             irqClear,
  input  logic [PRE_W-1:0] prescaleVal,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countVal,
  output logic [PRE_W-1:0] prescaleCnt,
  output logic             irqOut
);
  tmrStrobe_t strobe;
  logic       termEvt;

  tmr_ctrl #(.PRE_W(PRE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkEn(clkEn), .clkSel(clkSel),
    .sysTick(sysTick), .lpTick(lpTick), .prescaleVal(prescaleVal),
    .irqEn(irqEn), .irqClear(irqClear), .termEvt(termEvt),
    .strobe(strobe), .prescaleCnt(prescaleCnt), .irqOut(irqOut)
  );

  tmr_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countDown(countDown),
    .freeRun(freeRun), .reloadVal(reloadVal),
    .countVal(countVal), .termEvt(termEvt)
  );
endmodule

// File: tb/prescaled_reload_timer_tb_top.sv
`timescale 1ns/1ps
module prescaled_reload_timer_tb_top;
  localparam int CW = 8;
  localparam int PW = 5;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 0;
  logic rstN = 0;
  logic enable = 0, clkEn = 0, clkSel = 0, sysTick = 0, lpTick = 0;
  logic countDown = 0, freeRun = 0, irqEn = 0, irqClear = 0;
  logic [PW-1:0] prescaleVal = '0;
  logic [CW-1:0] reloadVal = '0;
  logic [CW-1:0] countVal;
  logic [PW-1:0] prescaleCnt;
  logic irqOut;

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R1";
  int mCnt = 0, mPre = 0, mFlag = 0;
  bit cmpOn = 0;

  always #2.5 clk = ~clk;

  prescaled_reload_timer #(.CNT_W(CW), .PRE_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkEn(clkEn), .clkSel(clkSel),
    .sysTick(sysTick), .lpTick(lpTick), .countDown(countDown), .freeRun(freeRun),
    .irqEn(irqEn), .irqClear(irqClear), .prescaleVal(prescaleVal),
    .reloadVal(reloadVal), .countVal(countVal), .prescaleCnt(prescaleCnt),
    .irqOut(irqOut)
  );

  // behavioural reference model
  always @(posedge clk) begin
    int tc;
    bit tk, stp;
    tc = 0;
    if (!rstN) begin
      mCnt = 0; mPre = 0; mFlag = 0;
    end else begin
      if (!enable) begin
        mCnt = 0; mPre = 0;
      end else begin
        tk = (clkSel ? sysTick : lpTick) && clkEn;
        stp = 0;
        if (tk) begin
          if (mPre >= prescaleVal) begin mPre = 0; stp = 1; end
          else mPre = mPre + 1;
        end
        if (stp) begin
          if (countDown) begin
            if (mCnt == 0) begin mCnt = reloadVal; tc = 1; end
            else mCnt = mCnt - 1;
          end else begin
            if (mCnt >= (freeRun ? MAXV : int'(reloadVal))) begin mCnt = 0; tc = 1; end
            else mCnt = mCnt + 1;
          end
        end
      end
      if (tc) mFlag = 1;
      else if (irqClear) mFlag = 0;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      check(curReq, countVal, mCnt, "countVal");
      check(curReq, prescaleCnt, mPre, "prescaleCnt");
      check("R8", irqOut, mFlag & irqEn, "irqOut");
    end
  end

  task automatic run(int n, int sysPat, int lpPat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sysTick = (sysPat == 0) ? 1'b0 : ((i % sysPat) == 0);
      lpTick  = (lpPat == 0) ? 1'b0 : ((i % lpPat) == 0);
    end
  endtask

  initial begin
    #20000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R1", countVal, 0, "reset countVal");
    check("R1", prescaleCnt, 0, "reset prescaleCnt");
    check("R1", irqOut, 0, "reset irqOut");
    rstN = 1;
    @(negedge clk);
    cmpOn = 1;

    // R5 up count, wrap at reload, fast strobe
    curReq = "R5"; enable = 1; clkEn = 1; clkSel = 1; irqEn = 1; reloadVal = 5;
    run(40, 1, 0);
    // R2 prescale divide 4 on system strobe
    curReq = "R2"; prescaleVal = 3;
    run(60, 1, 0);
    // R3 low-power strobe selected, system strobe ignored
    curReq = "R3"; clkSel = 0; prescaleVal = 1;
    run(80, 1, 3);
    // R2 full prescale field
    curReq = "R2"; clkSel = 1; prescaleVal = 31; reloadVal = 2;
    run(200, 1, 0);
    // R4 gate off holds
    curReq = "R4"; clkEn = 0;
    run(30, 1, 1);
    clkEn = 1; prescaleVal = 0;
    // R7 down count with reload, free-run ignored
    curReq = "R7"; countDown = 1; reloadVal = 4; freeRun = 1;
    run(40, 1, 0);
    // R10 disable zeros
    curReq = "R10"; enable = 0;
    run(10, 1, 0);
    @(negedge clk);
    check("R10", countVal, 0, "disabled countVal");
    // R6 free run up to max
    curReq = "R6"; enable = 1; countDown = 0; freeRun = 1; reloadVal = 5;
    seen = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      sysTick = 1;
      if (countVal > 5) seen = 1;
    end
    check("R6", seen, 1, "counted past reload");
    // R8 masked flag still set, then unmasked
    curReq = "R8"; freeRun = 0; reloadVal = 3; irqEn = 0;
    run(20, 1, 0);
    irqEn = 1;
    @(negedge clk);
    check("R8", irqOut, 1, "flag set while masked");
    // R9 clear pulses, including races with events
    curReq = "R9";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      irqClear = (i % 3) == 0;
    end
    @(negedge clk);
    irqClear = 0;
    sysTick = 0;
    @(negedge clk);
    irqClear = 1;
    @(negedge clk);
    irqClear = 0;
    @(negedge clk);
    check("R9", irqOut, 0, "cleared without event");
    cmpOn = 0;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule